// File: doc/BRIEF.md
# Blocked Parallel Prefix Scan Unit

The block takes a vector of N words and returns its inclusive prefix under one of six associative operators: wrapping add, unsigned maximum, unsigned minimum, bitwise AND, bitwise OR and bitwise XOR. A one-cycle start pulse captures the input vector and the operator code. Some cycles later the result vector appears, together with a one-cycle done pulse. Output word i holds the operator folded over input words 0 through i. The earlier word is always the left operand, so the ordering stays correct for an operator that is not commutative.

Internally the vector is cut into lanes of K = ceil(log2 N) words, and the last lane is padded with zeros when K does not divide N. The scan runs in three phases. First, every lane scans its own words one position per cycle. Second, a log-step scan runs over the lane tails, one doubling distance per cycle. Third, a single fix-up cycle folds the previous lane's finished tail into every non-final word of each later lane. The fixed-up words are written straight into the output register. This needs far fewer operator instances than a full log-step network over all N words, and it costs only a few extra cycles.

Top module: `prefix_scan`

## Requirements
- R1: After a run, output word i equals in[0] op in[1] op ... op in[i], folded left to right, with the earlier word always as the left operand.
- R2: Operator codes on op_sel are: 0 = add modulo 2^W, 1 = unsigned maximum, 2 = unsigned minimum, 3 = bitwise AND, 4 = bitwise OR, 5 = bitwise XOR. Codes 6 and 7 behave as add.
- R3: Word i of din and of dout sits at bit positions [i*W +: W].
- R4: din and op_sel are sampled only on the clock edge where start is accepted. Changing them afterwards has no effect on that run's result.
- R5: done is high for exactly one cycle. It rises K + ceil(log2(ceil(N/K))) clock edges after the edge that accepts start, where K = ceil(log2 N). With the defaults (N = 16) this is 6 edges.
- R6: A start pulse that arrives while a run is in progress is ignored. It produces no extra done pulse and does not alter the running result.
- R7: Reset clears done and dout to zero. dout changes only on the edge that raises done, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the block is idle |
| op_sel | input | 3 | Operator code, captured with start |
| din | input | N*W | Input vector, word i at [i*W +: W] |
| done | output | 1 | One-cycle pulse when dout is updated |
| dout | output | N*W | Registered prefix result vector |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a run. It must leave the phase counters and the captured data untouched. The stimulus raises start again, with a different vector and operator, one cycle after a run begins, while the lanes are still in their local scan. The bench then requires exactly one result, equal to the first vector's prefix, at the unchanged latency. Every run also scrambles din and op_sel right after start, so any late sampling shows up. The wrapping-add vector drives every lane tail past 2^W, which exercises the carry-free wrap through both the tail scan and the fix-up.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_MAX = 3'd1;
  localparam logic [2:0] OP_MIN = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_XOR = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCAL = 2'd1,
    ST_TAILS = 2'd2,
    ST_FIX = 2'd3
  } pscan_state_t;
endpackage

// File: rtl/pscan_op.sv
module pscan_op #(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import pscan_pkg::*;

  always_comb begin
    case (op)
      OP_MAX:  res = (lhs >= rhs) ? lhs : rhs;
      OP_MIN:  res = (lhs <= rhs) ? lhs : rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      default: res = lhs + rhs;
    endcase
  end
endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl #(
  parameter int K  = 4,
  parameter int S2 = 2,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          ld,
  output logic          p1_en,
  output logic          p2_en,
  output logic          p3_en,
  output logic [CW-1:0] cnt,
  output logic          done
);
  import pscan_pkg::*;

  localparam int LAT = K + S2;
  localparam pscan_state_t AFTER_LOAD  = (K > 1) ? ST_LOCAL : ((S2 > 0) ? ST_TAILS : ST_FIX);
  localparam pscan_state_t AFTER_LOCAL = (S2 > 0) ? ST_TAILS : ST_FIX;

  pscan_state_t state;
  logic         busy;

  assign busy  = (state != ST_IDLE);
  assign ld    = (state == ST_IDLE) && start;
  assign p1_en = (state == ST_LOCAL);
  assign p2_en = (state == ST_TAILS);
  assign p3_en = (state == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= p3_en;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= AFTER_LOAD;
            cnt   <= (K > 1) ? CW'(1) : '0;
          end
        end
        ST_LOCAL: begin
          if (cnt == CW'(K - 1)) begin
            state <= AFTER_LOCAL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAILS: begin
          if (cnt == CW'(S2 - 1)) begin
            state <= ST_FIX;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // Edges spent busy since the accepting edge; used only by the checks below.
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)       lat_q <= '0;
    else if (ld)   lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == CW'(LAT)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (lat_q == CW'($past(lat_q) + 1'b1)));
endmodule

// File: rtl/pscan_lane.sv
module pscan_lane #(
  parameter int W  = 16,
  parameter int K  = 4,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            ld,
  input  logic [K*W-1:0]  ld_data,
  input  logic [2:0]      op,
  input  logic            p1_en,
  input  logic [CW-1:0]   p1_idx,
  input  logic            tail_we,
  input  logic [W-1:0]    tail_wd,
  output logic [K*W-1:0]  words
);
  for (genvar e = 0; e < K; e++) begin : g_elem
    logic [W-1:0] r;
    assign words[e*W +: W] = r;

    if (e == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (ld)                         r <= ld_data[W-1:0];
        else if (tail_we && (K == 1))   r <= tail_wd;
      end
    end else begin : g_body
      logic [W-1:0] nxt;
      pscan_op #(.W(W)) u_op (
        .op  (op),
        .lhs (words[(e-1)*W +: W]),
        .rhs (r),
        .res (nxt)
      );
      always_ff @(posedge clk) begin
        if (ld)                                 r <= ld_data[e*W +: W];
        else if (p1_en && (p1_idx == CW'(e)))   r <= nxt;
        else if (tail_we && (e == K - 1))       r <= tail_wd;
      end
    end
  end
endmodule

// File: rtl/pscan_tails.sv
module pscan_tails #(
  parameter int W  = 16,
  parameter int L  = 4,
  parameter int S2 = 2,
  parameter int CW = 4
) (
  input  logic [2:0]     op,
  input  logic [CW-1:0]  step,
  input  logic [L*W-1:0] t_in,
  output logic [L*W-1:0] t_out
);
  localparam int SE = (S2 > 0) ? S2 : 1;

  for (genvar i = 0; i < L; i++) begin : g_tail
    logic [W-1:0] cand [SE];
    logic [W-1:0] pick;

    for (genvar j = 0; j < SE; j++) begin : g_step
      if ((S2 > 0) && (i >= (1 << j))) begin : g_comb
        pscan_op #(.W(W)) u_op (
          .op  (op),
          .lhs (t_in[(i - (1 << j))*W +: W]),
          .rhs (t_in[i*W +: W]),
          .res (cand[j])
        );
      end else begin : g_keep
        assign cand[j] = t_in[i*W +: W];
      end
    end

    always_comb begin
      pick = t_in[i*W +: W];
      for (int j = 0; j < SE; j++) begin
        if (step == CW'(j)) pick = cand[j];
      end
    end

    assign t_out[i*W +: W] = pick;
  end
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op_sel,
  input  logic [N*W-1:0] din,
  output logic           done,
  output logic [N*W-1:0] dout
);
  localparam int K  = ($clog2(N) > 0) ? $clog2(N) : 1;
  localparam int L  = (N + K - 1) / K;
  localparam int PN = L * K;
  localparam int S2 = $clog2(L);
  localparam int CW = $clog2(K + S2 + 2) + 1;

  logic          ld, p1_en, p2_en, p3_en;
  logic [CW-1:0] cnt;
  logic [2:0]    op_q;

  pscan_ctrl #(.K(K), .S2(S2), .CW(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ld    (ld),
    .p1_en (p1_en),
    .p2_en (p2_en),
    .p3_en (p3_en),
    .cnt   (cnt),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst)     op_q <= '0;
    else if (ld) op_q <= op_sel;
  end

  logic [PN*W-1:0] din_pad;
  always_comb begin
    din_pad = '0;
    din_pad[N*W-1:0] = din;
  end

  logic [PN*W-1:0] lane_words;
  logic [L*W-1:0]  tails;
  logic [L*W-1:0]  tails_nxt;
  logic [PN*W-1:0] fixed;

  for (genvar g = 0; g < L; g++) begin : g_lane
    pscan_lane #(.W(W), .K(K), .CW(CW)) u_lane (
      .clk     (clk),
      .ld      (ld),
      .ld_data (din_pad[g*K*W +: K*W]),
      .op      (op_q),
      .p1_en   (p1_en),
      .p1_idx  (cnt),
      .tail_we (p2_en),
      .tail_wd (tails_nxt[g*W +: W]),
      .words   (lane_words[g*K*W +: K*W])
    );

    assign tails[g*W +: W] = lane_words[(g*K + K - 1)*W +: W];

    for (genvar e = 0; e < K; e++) begin : g_fix
      if ((g == 0) || (e == K - 1)) begin : g_pass
        assign fixed[(g*K + e)*W +: W] = lane_words[(g*K + e)*W +: W];
      end else begin : g_carry
        pscan_op #(.W(W)) u_op (
          .op  (op_q),
          .lhs (tails[(g-1)*W +: W]),
          .rhs (lane_words[(g*K + e)*W +: W]),
          .res (fixed[(g*K + e)*W +: W])
        );
      end
    end
  end

  pscan_tails #(.W(W), .L(L), .S2(S2), .CW(CW)) u_tails (
    .op    (op_q),
    .step  (cnt),
    .t_in  (tails),
    .t_out (tails_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (p3_en) dout <= fixed[N*W-1:0];
  end

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));
endmodule

// File: tb/prefix_scan_tb_top.sv
`timescale 1ns/1ps
module prefix_scan_tb_top;
  localparam int N   = 16;
  localparam int W   = 16;
  localparam int K   = $clog2(N);
  localparam int L   = (N + K - 1) / K;
  localparam int S2  = $clog2(L);
  localparam int LAT = K + S2;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [2:0]     op_sel;
  logic [N*W-1:0] din;
  logic           done;
  logic [N*W-1:0] dout;

  always #2.5 clk = ~clk;

  prefix_scan #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .din(din), .done(done), .dout(dout)
  );

  int checks = 0;
  int errors = 0;
  int pcyc = 0;
  int hold_bad = 0;
  int pulse_bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic           prev_done = 1'b0;
  logic [N*W-1:0] last_dout = '0;

  logic [N*W-1:0] exp_q[$];
  int             st_q[$];
  string          tag_q[$];

  always @(posedge clk) pcyc <= pcyc + 1;

  function automatic logic [W-1:0] ref_op(input logic [2:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    case (op)
      3'd1: return (a > b) ? a : b;
      3'd2: return (a < b) ? a : b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return W'(a + b);
    endcase
  endfunction

  function automatic logic [N*W-1:0] ref_scan(input logic [2:0] op,
                                              input logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    logic [W-1:0]   acc;
    acc = v[W-1:0];
    r[W-1:0] = acc;
    for (int i = 1; i < N; i++) begin
      acc = ref_op(op, acc, v[i*W +: W]);
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  function automatic logic [N*W-1:0] hashed(input int seed);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 40503 + seed * 7919 + 1234);
    return v;
  endfunction

  // Driver: pushes the expectation, pulses start, then scrambles inputs (R4).
  task automatic launch(input logic [2:0] op, input logic [N*W-1:0] v, input string tag);
    @(negedge clk);
    din    = v;
    op_sel = op;
    start  = 1'b1;
    exp_q.push_back(ref_scan(op, v));
    st_q.push_back(pcyc);
    tag_q.push_back(tag);
    @(negedge clk);
    start  = 1'b0;
    din    = ~v;
    op_sel = op ^ 3'd1;
  endtask

  task automatic drain();
    repeat (LAT + 4) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (done && prev_done) pulse_bad++;
      if (!done && (dout !== last_dout)) hold_bad++;
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected done: got dout=%h expected no result", dout);
        end else begin
          logic [N*W-1:0] e;
          int    s;
          string t;
          e = exp_q.pop_front();
          s = st_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (dout !== e) begin
            errors++;
            for (int i = 0; i < N; i++) begin
              if (dout[i*W +: W] !== e[i*W +: W]) begin
                $display("FAIL %s word %0d: got %h expected %h", t, i, dout[i*W +: W], e[i*W +: W]);
                break;
              end
            end
          end
          checks++;
          if (pcyc - s != LAT + 1) begin
            errors++;
            $display("FAIL R5 latency (%s): got %0d expected %0d", t, pcyc - s - 1, LAT);
          end
        end
      end
      prev_done = done;
      last_dout = dout;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    rst = 1'b1; start = 1'b0; op_sel = '0; din = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 1'b0 || dout !== '0) begin
      errors++;
      $display("FAIL R7 reset state: got done=%b dout=%h expected 0 and 0", done, dout);
    end
    rst = 1'b0;
    last_dout = dout;
    mon_on = 1'b1;

    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i);
    launch(3'd0, v, "R1 R3 add ramp");  drain();
    // Known value check for the ramp: last word 120.
    checks++;
    if (dout[(N-1)*W +: W] !== W'(N*(N-1)/2)) begin
      errors++;
      $display("FAIL R1 ramp tail: got %0d expected %0d", dout[(N-1)*W +: W], N*(N-1)/2);
    end
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'hF000;
    launch(3'd0, v, "R2 add wrap");     drain();
    launch(3'd1, hashed(1), "R2 max");  drain();
    launch(3'd2, hashed(2), "R2 min");  drain();
    for (int i = 0; i < N; i++) v[i*W +: W] = ~(W'(1) << (i % W));
    launch(3'd3, v, "R2 and");          drain();
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(1) << ((i * 5) % W);
    launch(3'd4, v, "R2 or");           drain();
    launch(3'd5, hashed(3), "R2 xor");  drain();
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 3 + 1);
    launch(3'd6, v, "R2 code6 add");    drain();
    launch(3'd7, hashed(4), "R2 code7 add"); drain();

    // R6: start again while the first run is busy, with other data and op.
    launch(3'd0, hashed(5), "R6 first run kept");
    din = '1; op_sel = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 results outstanding: got %0d expected 0", exp_q.size());
    end
    checks++;
    if (pulse_bad != 0) begin
      errors++;
      $display("FAIL R5 done wider than one cycle: got %0d expected 0", pulse_bad);
    end
    checks++;
    if (hold_bad != 0) begin
      errors++;
      $display("FAIL R7 dout changed without done: got %0d expected 0", hold_bad);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule